// File: doc/BRIEF.md
# Single-Wire Serial RGB LED Transmitter

This block drives a chain of single-wire addressable RGB LEDs from one output line. Software writes colour bytes into a small transmit FIFO. Each byte is shifted out most significant bit first. Every bit is a fixed-length symbol that starts with a rising edge, and the length of the high phase carries the bit value: a short pulse means 0 and a long pulse means 1. A bit-period counter supplies two compare results, one for each pulse length, and the current data bit picks between them.

An LED takes 24 bits. Software writes them as three bytes in green, red, blue order. While the FIFO has room for another full LED word, a level request tells software to push three more bytes. When the FIFO runs dry the line is held low for a reset interval, which makes the LEDs latch what they received. This happens even if the FIFO empties part-way through a word, because the transmitter only stops at a byte boundary. The status line reports the whole activity window, from the first bit through the end of that interval.

Top module: `rgb_chain_tx`

## Requirements
- R1: After reset and while the FIFO stays empty, `led_out` is low and `busy` is low.
- R2: Every bit symbol lasts exactly 60 clock cycles and begins with `led_out` rising.
- R3: A 0 bit holds `led_out` high for 19 cycles and a 1 bit for 38 cycles; the line is low for the rest of the symbol.
- R4: Bytes are sent in the order they were written, each most significant bit first, so an LED word written as green, red, blue appears on the line as 24 bits in that order.
- R5: If the next byte is already in the FIFO when a byte finishes, the next symbol follows with no extra low time.
- R6: After the last queued byte, `led_out` stays low for at least 2800 cycles before any new rising edge. `busy` is high from the first bit until that low interval has completed, and then falls.
- R7: If the FIFO empties in the middle of an LED word, transmission stops after the current byte and the reset interval follows.
- R8: `room_irq` is high exactly when at least three of the four FIFO entries are free.
- R9: A write while the FIFO is full is discarded, and `ovf` is high for the one cycle after that write.
- R10: A byte written into an empty, idle block starts on the line on the second rising clock edge after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, 48 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe for one colour byte |
| wr_data | input | 8 | Colour byte to queue |
| led_out | output | 1 | Serial line to the first LED of the chain |
| busy | output | 1 | High from the first bit until the reset interval completes |
| room_irq | output | 1 | High while at least three FIFO entries are free |
| ovf | output | 1 | One-cycle pulse after a write was discarded on a full FIFO |

## Verification
The bench decodes the line by measuring every high phase and every symbol period, and compares the recovered bits with the bytes written.

It covers the following corner cases:
- **Start latency.** A single write into an idle block checks the start delay, which catches an extra pipeline stage.
- **Refill between words.** A two-LED frame is refilled through the room request. A transmitter that inserted dead time between bytes, or mis-sized the request, would show a broken period or a wrong `room_irq` level.
- **Overflow and underrun.** A burst of six writes overflows the FIFO and then leaves it to underrun mid-word. A design that accepted the extra byte would send 48 bits instead of 40. A design that padded to a word boundary would also send the wrong count. One that cut the reset interval short would show a low stretch under 2800 cycles before `busy` falls.

// File: rtl/rgb_chain_pkg.sv
package rgb_chain_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_e;

  localparam int LED_BYTES = 3;

endpackage

// File: rtl/rgb_tx_fifo.sv
module rgb_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [W-1:0]    wr_data,
  input  logic            rd_en,
  output logic [W-1:0]    rd_data,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] level,
  output logic            drop_o
);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wptr, wptr_n, rptr, rptr_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic            drop_q, drop_n;
  logic            do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt == '0);
  assign full    = (cnt == CNTW'(DEPTH));
  assign level   = cnt;
  assign rd_data = mem[rptr];
  assign drop_o  = drop_q;

  always_comb begin
    do_wr  = wr_en && !full;
    do_rd  = rd_en && !empty;
    wptr_n = do_wr ? bump(wptr) : wptr;
    rptr_n = do_rd ? bump(rptr) : rptr;
    drop_n = wr_en && full;
    cnt_n  = cnt;
    if (do_wr && !do_rd) cnt_n = cnt + 1'b1;
    else if (do_rd && !do_wr) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr   <= '0;
      rptr   <= '0;
      cnt    <= '0;
      drop_q <= 1'b0;
    end else begin
      wptr   <= wptr_n;
      rptr   <= rptr_n;
      cnt    <= cnt_n;
      drop_q <= drop_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !rd_en) |=> full);

  // R9
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> drop_o);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNTW'(DEPTH));

endmodule

// File: rtl/rgb_bit_timer.sv
module rgb_bit_timer #(
  parameter int BIT_CYC = 60,
  parameter int ZERO_HI = 19,
  parameter int ONE_HI  = 38,
  localparam int CW     = $clog2(BIT_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic bit_val,
  output logic wave,
  output logic bit_end
);

  logic [CW-1:0] cyc, cyc_n;
  logic          cmp_zero, cmp_one;

  always_comb begin
    if (!run) cyc_n = '0;
    else if (cyc == CW'(BIT_CYC - 1)) cyc_n = '0;
    else cyc_n = cyc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc_n;
  end

  assign cmp_zero = (cyc < CW'(ZERO_HI));
  assign cmp_one  = (cyc < CW'(ONE_HI));
  assign wave     = run && (bit_val ? cmp_one : cmp_zero);
  assign bit_end  = run && (cyc == CW'(BIT_CYC - 1));

  // R2
  sym_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == '0) |-> wave);

  // R3
  sym_tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc >= CW'(ONE_HI)) |-> !wave);

  // R2
  sym_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && run) |=> (cyc == '0));

endmodule

// File: rtl/rgb_chain_tx.sv
module rgb_chain_tx
  import rgb_chain_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int BIT_CYC    = 60,
  parameter int ZERO_HI    = 19,
  parameter int ONE_HI     = 38,
  parameter int GAP_CYC    = 2800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              led_out,
  output logic              busy,
  output logic              room_irq,
  output logic              ovf
);

  localparam int BW   = $clog2(DATA_W);
  localparam int GW   = $clog2(GAP_CYC);
  localparam int CNTW = $clog2(FIFO_DEPTH + 1);

  tx_state_e         state, state_n;
  logic [DATA_W-1:0] sh, sh_n;
  logic [BW-1:0]     bidx, bidx_n;
  logic [GW-1:0]     gcnt, gcnt_n;
  logic              pop;
  logic [DATA_W-1:0] q_data;
  logic              q_empty, q_full;
  logic [CNTW-1:0]   q_level;
  logic              run, bit_end, wave;

  rgb_tx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (pop),
    .rd_data (q_data),
    .empty   (q_empty),
    .full    (q_full),
    .level   (q_level),
    .drop_o  (ovf)
  );

  assign run = (state == ST_SEND);

  rgb_bit_timer #(.BIT_CYC(BIT_CYC), .ZERO_HI(ZERO_HI), .ONE_HI(ONE_HI)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .bit_val (sh[DATA_W-1]),
    .wave    (wave),
    .bit_end (bit_end)
  );

  always_comb begin
    state_n = state;
    sh_n    = sh;
    bidx_n  = bidx;
    gcnt_n  = gcnt;
    pop     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (!q_empty) begin
          pop     = 1'b1;
          sh_n    = q_data;
          bidx_n  = '0;
          state_n = ST_SEND;
        end
      end
      ST_SEND: begin
        if (bit_end) begin
          if (bidx == BW'(DATA_W - 1)) begin
            if (!q_empty) begin
              pop    = 1'b1;
              sh_n   = q_data;
              bidx_n = '0;
            end else begin
              gcnt_n  = '0;
              state_n = ST_GAP;
            end
          end else begin
            sh_n   = {sh[DATA_W-2:0], 1'b0};
            bidx_n = bidx + 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gcnt == GW'(GAP_CYC - 1)) state_n = ST_IDLE;
        else gcnt_n = gcnt + 1'b1;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sh    <= '0;
      bidx  <= '0;
      gcnt  <= '0;
    end else begin
      state <= state_n;
      sh    <= sh_n;
      bidx  <= bidx_n;
      gcnt  <= gcnt_n;
    end
  end

  assign led_out  = wave;
  assign busy     = (state != ST_IDLE);
  assign room_irq = (q_level <= CNTW'(FIFO_DEPTH - LED_BYTES));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !led_out);

  // R6
  gap_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |-> !led_out);

  // R6
  gap_no_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GAP) |=> (state != ST_SEND));

  // R10
  start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> led_out);

  // R7
  byte_edge_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && state_n == ST_GAP) |-> (bidx == BW'(DATA_W - 1) && q_empty));

endmodule

// File: tb/test_rgb_chain_tx.sv
module test_rgb_chain_tx;

  localparam int CLK_PERIOD = 10;
  localparam int SYM        = 60;
  localparam int HI0        = 19;
  localparam int HI1        = 38;
  localparam int GAP        = 2800;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       led_out, busy, room_irq, ovf;

  int total = 0;
  int bad   = 0;

  rgb_chain_tx i_rgb_chain_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .led_out  (led_out),
    .busy     (busy),
    .room_irq (room_irq),
    .ovf      (ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // line monitor: decodes pulses, checks periods, records low time at busy fall
  logic bits [0:255];
  int   nbits = 0;
  int   bad_hi = 0;
  int   bad_per = 0;
  int   hi_run = 0;
  int   lo_run = 0;
  int   last_hi = 0;
  int   last_gap = 0;
  bit   prev_l = 0;
  bit   prev_b = 0;
  bit   seen = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_l = 0; prev_b = 0; hi_run = 0; lo_run = 0; seen = 0;
    end else begin
      if (led_out) begin
        if (!prev_l) begin
          if (seen && lo_run < GAP && (last_hi + lo_run) != SYM) bad_per++;
          hi_run = 1;
        end else hi_run++;
      end else begin
        if (prev_l) begin
          last_hi = hi_run;
          seen = 1;
          if (hi_run == HI0) begin bits[nbits] = 1'b0; nbits++; end
          else if (hi_run == HI1) begin bits[nbits] = 1'b1; nbits++; end
          else bad_hi++;
          lo_run = 1;
        end else lo_run++;
      end
      if (prev_b && !busy) last_gap = lo_run;
      prev_l = led_out;
      prev_b = busy;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    wr_en   = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic cmp_bytes(input int start, input int nb, input logic [7:0] d [6],
                           input string req);
    int err = 0;
    for (int i = 0; i < nb; i++)
      for (int j = 0; j < 8; j++)
        if (bits[start + i*8 + j] !== d[i][7-j]) err++;
    chk(err == 0, req, err, 0);
  endtask

  task automatic t_reset();
    int hits = 0;
    chk(led_out == 1'b0, "R1 line low after reset", int'(led_out), 0);
    chk(busy == 1'b0, "R1 busy low after reset", int'(busy), 0);
    chk(room_irq == 1'b1, "R8 room request with empty fifo", int'(room_irq), 1);
    chk(ovf == 1'b0, "R9 no overflow after reset", int'(ovf), 0);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (led_out || busy) hits++;
    end
    chk(hits == 0 && nbits == 0, "R1 idle line stays low", hits + nbits, 0);
  endtask

  task automatic t_one_led();
    logic [7:0] d [6] = '{8'h00, 8'hFF, 8'h96, 8'h00, 8'h00, 8'h00};
    int s = nbits, bp = bad_per, bh = bad_hi;
    push(d[0]);
    chk(busy == 1'b0, "R10 not started after first edge", int'(busy), 0);
    push(d[1]);
    chk(busy && led_out, "R10 started on second edge", int'(busy && led_out), 1);
    push(d[2]);
    wait_idle();
    chk(nbits - s == 24, "R4 one LED word is 24 bits", nbits - s, 24);
    cmp_bytes(s, 3, d, "R4 green red blue msb first");
    chk(bad_hi == bh, "R3 high times 19 or 38", bad_hi - bh, 0);
    chk(bad_per == bp, "R2 symbol period 60", bad_per - bp, 0);
    chk(last_gap >= GAP + 1 && last_gap <= GAP + SYM,
        "R6 low interval before busy falls", last_gap, GAP + 1);
  endtask

  task automatic t_two_led();
    logic [7:0] d [6] = '{8'h12, 8'h34, 8'h56, 8'hF0, 8'h0F, 8'hC3};
    int s = nbits, bp = bad_per, n = 0;
    push(d[0]); push(d[1]); push(d[2]);
    chk(room_irq == 1'b0, "R8 request low with two queued", int'(room_irq), 0);
    while (!room_irq && n < 2000) begin @(negedge clk); n++; end
    chk(room_irq == 1'b1, "R8 request returns when space frees", int'(room_irq), 1);
    push(d[3]); push(d[4]); push(d[5]);
    chk(room_irq == 1'b0, "R8 request low with fifo full", int'(room_irq), 0);
    wait_idle();
    chk(nbits - s == 48, "R4 two LED words", nbits - s, 48);
    cmp_bytes(s, 6, d, "R4 two word order");
    chk(bad_per == bp, "R5 no gap between refilled bytes", bad_per - bp, 0);
    chk(room_irq == 1'b1, "R8 request high when drained", int'(room_irq), 1);
  endtask

  task automatic t_overflow();
    logic [7:0] d [6] = '{8'hA1, 8'h5A, 8'h3C, 8'h81, 8'h7E, 8'hEE};
    int s = nbits, bp = bad_per;
    for (int i = 0; i < 6; i++) push(d[i]);
    chk(ovf == 1'b1, "R9 overflow pulse after dropped write", int'(ovf), 1);
    @(negedge clk);
    chk(ovf == 1'b0, "R9 overflow pulse lasts one cycle", int'(ovf), 0);
    wait_idle();
    chk(nbits - s == 40, "R7 stop at byte boundary mid word", nbits - s, 40);
    cmp_bytes(s, 5, d, "R9 dropped byte absent");
    chk(bad_per == bp, "R2 period in partial word", bad_per - bp, 0);
    chk(last_gap >= GAP + 1 && last_gap <= GAP + SYM,
        "R7 reset interval after underrun", last_gap, GAP + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_one_led();
    t_two_led();
    t_overflow();
    repeat (50) @(negedge clk);
    chk(!led_out && !busy, "R1 idle after all frames", int'(led_out || busy), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule